// File: doc/BRIEF.md
# Frame and Superframe Sync Detector

This block sits after the symbol decision stage of a four-level line receiver. It takes one decided quaternary symbol per symbol strobe and finds the basic frame in that stream. A frame is marked by a nine-symbol sync word or by its polarity-inverted form. Once basic frame alignment is held, the block also locks to the superframe. The superframe is delimited by the inverted word, which recurs once every few frames.

Frame alignment runs through five states. While unaligned, the block searches every symbol position for a marker. After it finds one, it checks only the position one frame length later. Alignment is declared after three markers in a row at the right spacing. Two errored markers in a row are needed before alignment is dropped. Superframe lock is taken on the first inverted word that arrives at a frame position while frame alignment is already held. It is dropped on any spacing violation. The outputs are the two lock flags, a three-bit state code, and one-cycle strobes for frame and superframe boundaries.

Top module: `fsync_det`

## Requirements
- R1: `sym_q` is an index onto the levels -3,-1,+1,+3 (0..3). A received quat matches an expected +3 when its index is 2 or 3, and matches an expected -3 when its index is 0 or 1. A distance of two or more levels is an error. The sync word, in order of arrival, is +3 +3 -3 -3 -3 +3 -3 +3 +3. The inverted word swaps every sign. A marker is valid when all nine quats match one of the two words. No marker is recognized until nine symbol strobes have been received since reset.
- R2: In the searching state (code 000), every symbol position is checked. A valid marker moves the block to first-sense (code 001). All outputs are registered, so they change on the clock edge that takes the marker's ninth quat.
- R3: Outside the searching state, only the symbol position exactly FRAME_LEN strobes after the previous marker position is checked. Valid markers there move the block from 001 to second-sense (010), and then to aligned (011).
- R4: An invalid marker at the checked position in 001 or 010 returns the block to 000. Markers at other positions are ignored in every state except searching.
- R5: An invalid marker in 011 moves the block to losing (100). A valid marker in 100 returns it to 011. A second invalid marker in a row returns it to 000.
- R6: `bfs` is 1 exactly when the block is aligned or losing.
- R7: Superframe lock (`sfs`=1) is taken on the first valid inverted word at a checked position whose frame began with `bfs`=1. While `sfs` is 1, `ist` reads 111; otherwise `ist` gives the frame state code.
- R8: `sfs` drops when the checked position SF_FRAMES frames after the last accepted inverted word carries no inverted word.
- R9: `sfs` drops when an inverted word arrives at a checked position earlier than SF_FRAMES frames after the last one.
- R10: `sfs` drops whenever frame alignment is lost, and `sfs` is never 1 while `bfs` is 0.
- R11: `frame_stb` pulses for one cycle after each checked position that is reached with `bfs`=1. `sf_stb` pulses in the same cycle when an inverted word is accepted there.
- R12: Cycles with `sym_vld` low change no state, whatever `sym_q` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_vld | input | 1 | Symbol strobe, one per decided quat |
| sym_q | input | 2 | Decided quat index (0=-3 .. 3=+3) |
| bfs | output | 1 | Basic frame alignment held |
| sfs | output | 1 | Superframe alignment held |
| ist | output | 3 | State code; 111 when superframe locked |
| frame_stb | output | 1 | Frame boundary pulse |
| sf_stb | output | 1 | Superframe boundary pulse |

## Verification
The bench targets the following faults:
- A pre-reset window: after reset the bench feeds a partial inverted word that would match against zero-filled history. A design without a fill guard would leave the searching state too early.
- The single-error tolerance: one errored word must not drop alignment. A design that collapsed the losing state would fall to 000 instead of 100.
- Off-position markers: the bench places a sync word mid-frame while aligned. A design that keeps searching would move or re-align.
- Superframe loss: an inverted word arrives one frame late, and another arrives early. A design that only counted, or only matched, would keep `sfs` high in one of the two cases.
- Idle strobes carrying sync-like data: these catch a design that samples `sym_q` without `sym_vld`.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  localparam int WORD_LEN = 9;
  // sign pattern of the sync word, first received quat in the MSB
  localparam logic [WORD_LEN-1:0] SW_SIGNS = 9'b110001011;
  localparam logic [2:0] IST_FULL = 3'b111;

  typedef enum logic [2:0] {
    ST_LOST   = 3'b000,
    ST_SENSE1 = 3'b001,
    ST_SENSE2 = 3'b010,
    ST_SYNC   = 3'b011,
    ST_LOSING = 3'b100
  } fsd_state_e;

  // within one level of +3 (index 2 or 3)
  function automatic logic quat_is_high(input logic [1:0] q);
    return (2'd3 - q) <= 2'd1;
  endfunction
endpackage

// File: rtl/fsd_window.sv
module fsd_window
  import fsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_vld,
  input  logic [1:0] sym_q,
  output logic       sw_ok,
  output logic       isw_ok
);
  localparam int FILL_W = $clog2(WORD_LEN + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WORD_LEN);

  logic [WORD_LEN-1:0] win_q, win_nxt;
  logic [FILL_W-1:0]   fill_q, fill_nxt;
  logic                full_nxt;

  always_comb begin
    win_nxt  = {win_q[WORD_LEN-2:0], quat_is_high(sym_q)};
    fill_nxt = (fill_q == FILL_MAX) ? fill_q : fill_q + 1'b1;
    full_nxt = (fill_nxt == FILL_MAX);
    sw_ok    = sym_vld && full_nxt && (win_nxt == SW_SIGNS);
    isw_ok   = sym_vld && full_nxt && (win_nxt == ~SW_SIGNS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (sym_vld) begin
      win_q  <= win_nxt;
      fill_q <= fill_nxt;
    end
  end
endmodule

// File: rtl/fsd_frame_fsm.sv
module fsd_frame_fsm
  import fsd_pkg::*;
#(
  parameter int FRAME_LEN = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_vld,
  input  logic       sw_ok,
  input  logic       isw_ok,
  output fsd_state_e state,
  output logic       at_mark,
  output logic       lose_nxt,
  output logic       bfs
);
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

  fsd_state_e        state_q, state_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              mark_ok;

  always_comb begin
    mark_ok   = sw_ok || isw_ok;
    at_mark   = sym_vld && (state_q != ST_LOST) && (cnt_q == CNT_LAST);
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    if (sym_vld) begin
      if (state_q == ST_LOST) cnt_nxt = '0;
      else if (at_mark)       cnt_nxt = '0;
      else                    cnt_nxt = cnt_q + 1'b1;
    end
    case (state_q)
      ST_LOST:   if (sym_vld && mark_ok) state_nxt = ST_SENSE1;
      ST_SENSE1: if (at_mark) state_nxt = mark_ok ? ST_SENSE2 : ST_LOST;
      ST_SENSE2: if (at_mark) state_nxt = mark_ok ? ST_SYNC : ST_LOST;
      ST_SYNC:   if (at_mark && !mark_ok) state_nxt = ST_LOSING;
      ST_LOSING: if (at_mark) state_nxt = mark_ok ? ST_SYNC : ST_LOST;
      default:   state_nxt = ST_LOST;
    endcase
    lose_nxt = at_mark && (state_nxt == ST_LOST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOST;
      cnt_q   <= '0;
    end else if (sym_vld) begin
      state_q <= state_nxt;
      cnt_q   <= cnt_nxt;
    end
  end

  assign state = state_q;
  assign bfs   = (state_q == ST_SYNC) || (state_q == ST_LOSING);
endmodule

// File: rtl/fsd_sf_track.sv
module fsd_sf_track #(
  parameter int SF_FRAMES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic at_mark,
  input  logic bfs,
  input  logic lose_nxt,
  input  logic isw_ok,
  output logic sfs,
  output logic frame_stb,
  output logic sf_stb
);
  localparam int IDX_W = (SF_FRAMES > 1) ? $clog2(SF_FRAMES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SF_FRAMES - 1);

  logic             sfs_q, sfs_nxt, sf_hit, upd;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             fstb_q, sfstb_q;

  always_comb begin
    upd     = at_mark && bfs;
    sfs_nxt = sfs_q;
    idx_nxt = idx_q;
    sf_hit  = 1'b0;
    if (upd) begin
      if (lose_nxt) begin
        sfs_nxt = 1'b0;
      end else if (isw_ok) begin
        if (!sfs_q || idx_q == IDX_LAST) begin
          sfs_nxt = 1'b1;
          idx_nxt = '0;
          sf_hit  = 1'b1;
        end else begin
          sfs_nxt = 1'b0;
        end
      end else if (sfs_q) begin
        if (idx_q == IDX_LAST) sfs_nxt = 1'b0;
        else                   idx_nxt = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfs_q <= 1'b0;
      idx_q <= '0;
    end else if (upd) begin
      sfs_q <= sfs_nxt;
      idx_q <= idx_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fstb_q  <= 1'b0;
      sfstb_q <= 1'b0;
    end else begin
      fstb_q  <= upd;
      sfstb_q <= sf_hit;
    end
  end

  assign sfs       = sfs_q;
  assign frame_stb = fstb_q;
  assign sf_stb    = sfstb_q;
endmodule

// File: rtl/fsync_det.sv
module fsync_det
  import fsd_pkg::*;
#(
  parameter int FRAME_LEN = 120,
  parameter int SF_FRAMES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_vld,
  input  logic [1:0] sym_q,
  output logic       bfs,
  output logic       sfs,
  output logic [2:0] ist,
  output logic       frame_stb,
  output logic       sf_stb
);
  logic       sw_ok, isw_ok, at_mark, lose_nxt;
  fsd_state_e state;

  fsd_window u_win (
    .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_q(sym_q),
    .sw_ok(sw_ok), .isw_ok(isw_ok)
  );

  fsd_frame_fsm #(.FRAME_LEN(FRAME_LEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sw_ok(sw_ok),
    .isw_ok(isw_ok), .state(state), .at_mark(at_mark),
    .lose_nxt(lose_nxt), .bfs(bfs)
  );

  fsd_sf_track #(.SF_FRAMES(SF_FRAMES)) u_sf (
    .clk(clk), .rst_n(rst_n), .at_mark(at_mark), .bfs(bfs),
    .lose_nxt(lose_nxt), .isw_ok(isw_ok), .sfs(sfs),
    .frame_stb(frame_stb), .sf_stb(sf_stb)
  );

  assign ist = sfs ? IST_FULL : 3'(state);
endmodule

// File: rtl/fsync_det_chk.sv
module fsync_det_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_vld,
  input logic       bfs,
  input logic       sfs,
  input logic [2:0] ist,
  input logic       frame_stb,
  input logic       sf_stb
);
  a_r10_sfs_needs_bfs: assert property (@(posedge clk) disable iff (!rst_n)
    sfs |-> bfs);
  a_r7_full_code: assert property (@(posedge clk) disable iff (!rst_n)
    sfs |-> (ist == 3'b111));
  a_r6_bfs_code: assert property (@(posedge clk) disable iff (!rst_n)
    bfs |-> (ist == 3'b011 || ist == 3'b100 || ist == 3'b111));
  a_r6_nobfs_code: assert property (@(posedge clk) disable iff (!rst_n)
    !bfs |-> (ist == 3'b000 || ist == 3'b001 || ist == 3'b010));
  a_r11_sf_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sf_stb |-> frame_stb);
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb);
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> ($stable(ist) && !frame_stb));
  a_r2_leave_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (ist == 3'b000) |=> (ist == 3'b000 || ist == 3'b001));
  a_r4_sense1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ist == 3'b001) |=> (ist == 3'b000 || ist == 3'b001 || ist == 3'b010));
endmodule

bind fsync_det fsync_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .bfs(bfs), .sfs(sfs),
  .ist(ist), .frame_stb(frame_stb), .sf_stb(sf_stb)
);

// File: tb/sim_fsync_det.sv
module sim_fsync_det;
  localparam int CLK_PERIOD = 10;
  localparam int FL = 120;
  localparam int SFN = 8;
  localparam bit [8:0] SWV = 9'b110001011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_vld = 1'b0;
  logic [1:0] sym_q = 2'd0;
  logic bfs, sfs, frame_stb, sf_stb;
  logic [2:0] ist;

  int n_chk = 0, n_err = 0, n_put = 0, n_f = 0, n_sf = 0;
  bit done = 0;

  fsync_det #(.FRAME_LEN(FL), .SF_FRAMES(SFN)) u0 (
    .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_q(sym_q),
    .bfs(bfs), .sfs(sfs), .ist(ist), .frame_stb(frame_stb), .sf_stb(sf_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_win[$];
  int m_st, m_cnt, m_fidx;
  bit m_sfs, m_fstb, m_sfstb;

  always @(posedge clk or negedge rst_n) begin
    bit swm, iswm, ok, was_bfs, fs, ss;
    int nst;
    if (!rst_n) begin
      m_win.delete(); m_st = 0; m_cnt = 0; m_fidx = 0;
      m_sfs = 0; m_fstb = 0; m_sfstb = 0;
    end else begin
      fs = 0; ss = 0;
      if (sym_vld) begin
        m_win.push_back(sym_q >= 2);
        if (m_win.size() > 9) void'(m_win.pop_front());
        swm = (m_win.size() == 9); iswm = swm;
        for (int i = 0; i < m_win.size(); i++) begin
          if (m_win[i] != SWV[8-i]) swm = 0;
          if (m_win[i] == SWV[8-i]) iswm = 0;
        end
        ok = swm || iswm;
        if (m_st == 0) begin
          if (ok) begin m_st = 1; m_cnt = 0; end
        end else begin
          m_cnt++;
          if (m_cnt == FL) begin
            m_cnt = 0;
            was_bfs = (m_st == 3 || m_st == 4);
            case (m_st)
              1: nst = ok ? 2 : 0;
              2: nst = ok ? 3 : 0;
              3: nst = ok ? 3 : 4;
              default: nst = ok ? 3 : 0;
            endcase
            if (was_bfs) begin
              fs = 1;
              if (nst == 0) m_sfs = 0;
              else if (iswm) begin
                if (!m_sfs || m_fidx == SFN-1) begin m_sfs = 1; m_fidx = 0; ss = 1; end
                else m_sfs = 0;
              end else if (m_sfs) begin
                if (m_fidx == SFN-1) m_sfs = 0; else m_fidx++;
              end
            end
            m_st = nst;
          end
        end
      end
      m_fstb = fs; m_sfstb = ss;
    end
  end

  // every-cycle comparison and strobe counters
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 bfs", bfs, (m_st == 3 || m_st == 4));
      chk("R3 ist", ist, m_sfs ? 7 : m_st);
      chk("R7 sfs", sfs, m_sfs);
      chk("R11 frame_stb", frame_stb, m_fstb);
      chk("R11 sf_stb", sf_stb, m_sfstb);
      if (frame_stb) n_f++;
      if (sf_stb) n_sf++;
    end
  end

  function automatic logic [1:0] lvl(input bit s, input int v);
    if (s) return (v % 2) ? 2'd3 : 2'd2;
    return (v % 2) ? 2'd0 : 2'd1;
  endfunction

  task automatic put(input logic [1:0] q);
    @(negedge clk);
    sym_vld = 1'b1; sym_q = q;
    n_put++;
    if (n_put % 7 == 0) begin
      @(negedge clk);
      sym_vld = 1'b0; sym_q = 2'd3;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    sym_vld = 1'b0;
  endtask

  // kind: 0 sync word, 1 inverted word, 2 no marker
  task automatic send_frame(input int kind, input bit err, input bit offmark);
    for (int i = 0; i < FL; i++) begin
      bit s;
      s = i[0];
      if (i < 9 && kind != 2) s = SWV[8-i] ^ (kind == 1);
      if (i == 4 && err) s = ~s;
      if (offmark && i >= 50 && i < 59) s = SWV[58-i];
      put(lvl(s, i));
    end
    settle();
  endtask

  initial begin
    int f0, s0;
    repeat (3) @(negedge clk);
    chk("R6 reset bfs", bfs, 0);
    chk("R2 reset ist", ist, 0);
    chk("R10 reset sfs", sfs, 0);
    chk("R11 reset frame_stb", frame_stb, 0);
    rst_n = 1'b1;
    // partial inverted word right after reset
    for (int i = 2; i < 9; i++) put(lvl(~SWV[8-i], i));
    settle();
    chk("R1 no match before nine quats", ist, 0);
    for (int i = 0; i < 20; i++) put(lvl(i[0], i));
    send_frame(0, 0, 0); chk("R2 first marker", ist, 1);
    send_frame(0, 0, 0); chk("R3 second marker", ist, 2);
    send_frame(0, 0, 0); chk("R3 aligned", ist, 3); chk("R6 bfs aligned", bfs, 1);
    f0 = n_f; s0 = n_sf;
    send_frame(0, 0, 1); chk("R4 off-position marker ignored", ist, 3);
    send_frame(0, 1, 0); chk("R5 one error losing", ist, 4); chk("R5 bfs kept", bfs, 1);
    send_frame(0, 0, 0); chk("R5 recover", ist, 3);
    send_frame(1, 0, 0); chk("R7 sfs acquired", sfs, 1); chk("R7 full code", ist, 7);
    for (int k = 0; k < 7; k++) send_frame(0, 0, 0);
    send_frame(1, 0, 0); chk("R7 sfs held", sfs, 1);
    chk("R11 frame strobes", n_f - f0, 12);
    chk("R11 superframe strobes", n_sf - s0, 2);
    // idle cycles with sync-like data
    f0 = n_f;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); sym_vld = 1'b0; sym_q = lvl(SWV[i % 9], i);
    end
    settle();
    chk("R12 idle ist", ist, 7); chk("R12 idle strobes", n_f - f0, 0);
    for (int k = 0; k < 7; k++) send_frame(0, 0, 0);
    chk("R8 sfs before deadline", sfs, 1);
    send_frame(0, 0, 0); chk("R8 missing inverted word", sfs, 0); chk("R8 bfs", bfs, 1);
    send_frame(1, 0, 0); chk("R7 reacquire", sfs, 1);
    for (int k = 0; k < 3; k++) send_frame(0, 0, 0);
    send_frame(1, 0, 0); chk("R9 early inverted word", sfs, 0); chk("R9 ist", ist, 3);
    send_frame(1, 0, 0); chk("R7 reacquire again", sfs, 1);
    send_frame(0, 1, 0); chk("R5 error under sfs", ist, 7);
    send_frame(0, 1, 0);
    chk("R10 sfs with bfs loss", sfs, 0); chk("R5 second error lost", ist, 0);
    chk("R6 bfs lost", bfs, 0);
    send_frame(0, 0, 0); chk("R2 hunt again", ist, 1);
    send_frame(2, 0, 0); chk("R4 sense1 miss", ist, 0);
    send_frame(0, 0, 0); send_frame(0, 0, 0); chk("R4 sense2 reached", ist, 2);
    send_frame(2, 0, 0); chk("R4 sense2 miss", ist, 0);
    repeat (5) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule